// File: doc/BRIEF.md
# Two-Wire Serial Register-Write Bridge

This block takes register writes from a two-wire serial master (a clock line and a data line, framed with start and stop conditions much like I2C but with no device address and no acknowledge bits). It turns each write into a single-cycle write on a parallel settings bus. Each write carries an 8-bit register address and a 32-bit data word.

Both serial lines arrive asynchronously to the system clock. The block passes each one through a three-register chain and finds edges by comparing the two oldest stages. A framing state machine waits for a start condition, then shifts in 40 bits, each sampled on a rising serial-clock edge. It then raises the write strobe for one cycle, with the captured address and data on the output buses. The master must hold the serial clock high for at least four system clock periods and low for at least four.

Top module: `serial_reg_bridge`

## Requirements
- R1: A synchronous active-high reset forces `wr_stb` low, clears `wr_addr` and `wr_data` to zero, and leaves the block idle. After reset, no write occurs until a start condition is seen.
- R2: While idle, serial clock pulses with changing data produce no write, and the outputs keep their values.
- R3: After a start condition (data line falling while the clock line is high), the first 8 bits received form the address and the next 32 form the data. Both fields arrive most significant bit first, and together they are presented as one write.
- R4: Each bit is the data line level at a rising edge of the serial clock. Data line toggling while the serial clock is low does not affect the captured value.
- R5: `wr_stb` is high for exactly one system clock cycle per complete frame. It rises in the third system clock cycle after the cycle in which the 40th rising serial-clock edge is applied at the input.
- R6: `wr_addr` and `wr_data` change only together with `wr_stb`. They hold their values until the next complete frame.
- R7: A start condition at any point in a frame discards the partial frame. Reception then restarts at address bit 7.
- R8: A stop condition (data line rising while the clock line is high) before all 40 bits have arrived discards the frame with no write. The block then returns to idle.
- R9: Serial clock pulses after the 40th bit, and pulses after a stop, produce no further write until the next start condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line, asynchronous |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 8 | Register address, valid with `wr_stb` |
| wr_data | output | 32 | Write data, valid with `wr_stb` |

## Verification
The assertions check these behaviours on every cycle:
- the strobe lasts one cycle and follows a detected serial-clock rise in the data phase;
- the output buses never move without the strobe;
- a start always leaves the machine at address bit 7;
- a stop always returns it to idle with no strobe;
- the bit counter stays within its field.

Only the bench scenarios can show the rest:
- the bit order of address and data;
- the exact three-cycle latency of the strobe through the synchronizers;
- immunity to data glitches while the clock is low;
- that stray clock pulses outside a frame and extra bits after a frame are ignored.

// File: rtl/serial_reg_bridge.sv
module serial_reg_bridge #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int SYNC_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2((DATA_W > ADDR_W) ? DATA_W : ADDR_W);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_TAIL = 3'd4
  } state_t;

  logic [SYNC_LEN-1:0] scl_sync, sda_sync;
  logic                scl_now, scl_old, sda_now, sda_old;
  logic                scl_rise, sda_rise, sda_fall;
  logic                start_det, stop_det;
  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic [FRAME_W-1:0]  shreg, shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
    end else begin
      scl_sync <= {scl_sync[SYNC_LEN-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_LEN-2:0], sda_in};
    end
  end

  assign scl_now   = scl_sync[SYNC_LEN-2];
  assign scl_old   = scl_sync[SYNC_LEN-1];
  assign sda_now   = sda_sync[SYNC_LEN-2];
  assign sda_old   = sda_sync[SYNC_LEN-1];
  assign scl_rise  = scl_now & ~scl_old;
  assign sda_rise  = sda_now & ~sda_old;
  assign sda_fall  = ~sda_now & sda_old;
  assign start_det = sda_fall & scl_now & scl_old;
  assign stop_det  = sda_rise & scl_now & scl_old;
  assign shifted   = {shreg[FRAME_W-2:0], sda_now};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR;
        cnt   <= '0;
        shreg <= '0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (scl_rise) begin
        case (state)
          ST_ADDR: begin
            shreg <= shifted;
            if (cnt == ADDR_LAST) begin
              cnt   <= '0;
              state <= ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            shreg <= shifted;
            if (cnt == DATA_LAST) begin
              cnt                <= '0;
              state              <= ST_TAIL;
              wr_stb             <= 1'b1;
              {wr_addr, wr_data} <= shifted;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/serial_reg_bridge_chk.sv
module serial_reg_bridge_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_rise,
  input logic              start_det,
  input logic              stop_det,
  input logic [2:0]        state,
  input logic [CNT_W-1:0]  cnt,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_ADDR = 3'd1;
  localparam logic [2:0] S_DATA = 3'd2;

  assert_stb_single_R5: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  assert_stb_after_rise_R5: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> ($past(scl_rise) && $past(state) == S_DATA));

  assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |-> ($stable(wr_addr) && $stable(wr_data)));

  assert_start_restarts_R7: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == S_ADDR && cnt == '0));

  assert_stop_discards_R8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == S_IDLE && !wr_stb));

  assert_addr_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_ADDR) |-> (32'(cnt) < ADDR_W));

  assert_data_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA) |-> (32'(cnt) < DATA_W));

endmodule

bind serial_reg_bridge serial_reg_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .scl_rise(scl_rise), .start_det(start_det),
  .stop_det(stop_det), .state(state), .cnt(cnt), .wr_stb(wr_stb),
  .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/tb_serial_reg_bridge.sv
module tb_serial_reg_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_r = 1'b1;
  logic        sda_r = 1'b1;
  logic        wr_stb;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;
  int stb_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_reg_bridge dut (
    .clk(clk), .rst(rst), .scl_in(scl_r), .sda_in(sda_r),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) if (wr_stb) stb_cnt++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit glitch = 0);
    scl_r = 1'b0;
    wait_n(1);
    if (glitch) begin
      sda_r = ~b; wait_n(1);
      sda_r = b;  wait_n(1);
      sda_r = ~b; wait_n(1);
    end else begin
      wait_n(1);
    end
    sda_r = b;
    wait_n(2);
    scl_r = 1'b1;
    wait_n(4);
  endtask

  task automatic do_start();
    scl_r = 1'b0; wait_n(2);
    sda_r = 1'b1; wait_n(2);
    scl_r = 1'b1; wait_n(4);
    sda_r = 1'b0; wait_n(4);
  endtask

  task automatic do_stop();
    scl_r = 1'b0; wait_n(2);
    sda_r = 1'b0; wait_n(2);
    scl_r = 1'b1; wait_n(4);
    sda_r = 1'b1; wait_n(4);
  endtask

  task automatic send_bits(input logic [39:0] v, input int n, input bit glitch = 0);
    for (int i = 39; i > 39 - n; i--) send_bit(v[i], glitch);
  endtask

  task automatic t_reset();
    wait_n(1);
    chk("R1 strobe low", 64'(wr_stb), 64'd0);
    chk("R1 addr zero", 64'(wr_addr), 64'd0);
    chk("R1 data zero", 64'(wr_data), 64'd0);
  endtask

  task automatic t_idle_pulses();
    int s0 = stb_cnt;
    send_bits({8'h5A, 32'hFFFF_0000}, 40);
    wait_n(8);
    chk("R2 no write while idle", 64'(stb_cnt - s0), 64'd0);
    chk("R2 addr kept", 64'(wr_addr), 64'd0);
  endtask

  task automatic t_full_frame_timed();
    int s0 = stb_cnt;
    logic [39:0] f = {8'hC3, 32'h8123_4567};
    do_start();
    send_bits(f, 39);
    scl_r = 1'b0; wait_n(2);
    sda_r = f[0]; wait_n(2);
    scl_r = 1'b1;
    @(negedge clk); chk("R5 no early strobe +1", 64'(wr_stb), 64'd0);
    @(negedge clk); chk("R5 no early strobe +2", 64'(wr_stb), 64'd0);
    @(negedge clk); chk("R5 strobe at +3", 64'(wr_stb), 64'd1);
    chk("R3 address MSB first", 64'(wr_addr), 64'hC3);
    chk("R3 data MSB first", 64'(wr_data), 64'h8123_4567);
    @(negedge clk); chk("R5 strobe one cycle", 64'(wr_stb), 64'd0);
    wait_n(4);
    do_stop();
    chk("R5 one strobe per frame", 64'(stb_cnt - s0), 64'd1);
  endtask

  task automatic t_glitch_frame();
    int s0 = stb_cnt;
    do_start();
    send_bits({8'h3C, 32'h0F0F_A5A5}, 40, 1);
    wait_n(4);
    do_stop();
    chk("R4 glitch-free address", 64'(wr_addr), 64'h3C);
    chk("R4 glitch-free data", 64'(wr_data), 64'h0F0F_A5A5);
    chk("R4 one write", 64'(stb_cnt - s0), 64'd1);
  endtask

  task automatic t_extra_bits();
    int s0 = stb_cnt;
    do_start();
    send_bits({8'h11, 32'h2222_3333}, 40);
    send_bits({8'hFF, 32'h0}, 6);
    do_stop();
    chk("R9 extra bits no second write", 64'(stb_cnt - s0), 64'd1);
    chk("R6 addr held after extra bits", 64'(wr_addr), 64'h11);
    chk("R6 data held after extra bits", 64'(wr_data), 64'h2222_3333);
  endtask

  task automatic t_stop_abort();
    int s0 = stb_cnt;
    do_start();
    send_bits({8'hEE, 32'hDEAD_BEEF}, 20);
    do_stop();
    wait_n(8);
    chk("R8 short frame no write", 64'(stb_cnt - s0), 64'd0);
    chk("R6 addr held after abort", 64'(wr_addr), 64'h11);
    chk("R6 data held after abort", 64'(wr_data), 64'h2222_3333);
  endtask

  task automatic t_restart();
    int s0 = stb_cnt;
    do_start();
    send_bits({8'hFF, 32'hFFFF_FFFF}, 12);
    do_start();
    send_bits({8'h47, 32'h1357_9BDF}, 40);
    do_stop();
    chk("R7 restart address", 64'(wr_addr), 64'h47);
    chk("R7 restart data", 64'(wr_data), 64'h1357_9BDF);
    chk("R7 single write", 64'(stb_cnt - s0), 64'd1);
  endtask

  task automatic t_after_stop();
    int s0 = stb_cnt;
    send_bits({8'h99, 32'h8888_7777}, 40);
    wait_n(8);
    chk("R9 pulses after stop ignored", 64'(stb_cnt - s0), 64'd0);
    chk("R9 addr kept", 64'(wr_addr), 64'h47);
  endtask

  task automatic t_mid_reset();
    int s0 = stb_cnt;
    do_start();
    send_bits({8'hAB, 32'hCDEF_0123}, 10);
    scl_r = 1'b0; wait_n(2);
    sda_r = 1'b1; wait_n(2);
    scl_r = 1'b1; wait_n(4);
    rst = 1'b1; wait_n(2);
    rst = 1'b0; wait_n(4);
    chk("R1 reset clears addr", 64'(wr_addr), 64'd0);
    chk("R1 reset clears data", 64'(wr_data), 64'd0);
    send_bits({8'hAB, 32'hCDEF_0123}, 40);
    wait_n(8);
    chk("R1 idle after reset", 64'(stb_cnt - s0), 64'd0);
  endtask

  initial begin
    rst = 1'b1;
    wait_n(6);
    rst = 1'b0;
    wait_n(4);
    t_reset();
    t_idle_pulses();
    t_full_frame_timed();
    t_glitch_frame();
    t_extra_bits();
    t_stop_abort();
    t_restart();
    t_after_stop();
    t_mid_reset();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule